// File: doc/BRIEF.md
# Parallel EEPROM Write Capture and Page Window

This block is the write front end of a parallel EEPROM. Host strobes arrive as asynchronous active-low chip select, write enable and output enable pins. A fast system clock samples them through two-flop synchronisers. The block works out when a host write cycle opens and closes, and latches the address and data word at the right points.

The capture rule depends on which strobe moves last or first. The address is taken when the later of the two strobes goes low. The data word is taken when the first of them goes high, and at that moment a one-cycle pulse tells the page buffer to store the byte.

Each write-enable fall opens, or reopens, a page window that behaves like a retriggerable one-shot. When the window lapses with at least one byte stored, a fixed programming interval follows. During that interval the block reports busy and ignores all strobes. Both the window length and the programming length are given in system-clock cycles.

Top module: `page_write_capture`

## Requirements
- R1: After reset, `capAddr`, `capData`, `bufWrite`, `pageOpen` and `busy` are all 0.
- R2: A write cycle opens only if `oeN` is high in the synchronised cycle where both `csN` and `weN` become low. With `oeN` low, neither the address nor the data is captured, no pulse is produced, and a `weN` fall does not open the window.
- R3: `capAddr` takes `addrIn` when the later of `csN` and `weN` falls. This holds for a write-enable-controlled order and for a chip-select-controlled order. The new value is visible after the third rising clock edge following the pin change: two synchroniser stages plus the edge register.
- R4: `capData` takes `dataIn` when the first of `csN` and `weN` rises after a write cycle opened. In the same cycle `bufWrite` is high for exactly one clock.
- R5: A `weN` fall opens the page window and sets `pageOpen`. This applies with `oeN` high and `busy` low, whether or not `csN` is low.
- R6: A further `weN` fall while `pageOpen` is set restarts the window count from zero.
- R7: The window lapses once it has advanced for `WINDOW_CYC` cycles with no new `weN` fall. The count does not advance while a write cycle is open. At expiry `pageOpen` clears. If a byte was stored since the last programming interval, `busy` sets in that same cycle.
- R8: `busy` stays high for exactly `PROG_CYC` cycles and then clears by itself.
- R9: While `busy` is high, strobes are ignored: `capAddr` and `capData` hold, `bufWrite` stays low, and `pageOpen` stays low.
- R10: If the window lapses with no byte stored, `pageOpen` clears and `busy` stays low.
- R11: While both strobes are held low, the window cannot lapse, however long the write cycle lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select pin, active low, asynchronous |
| weN | input | 1 | Write enable pin, active low, asynchronous |
| oeN | input | 1 | Output enable pin, active low, asynchronous |
| addrIn | input | ADDR_W | Host address bus |
| dataIn | input | DATA_W | Host data bus |
| capAddr | output | ADDR_W | Last captured write address |
| capData | output | DATA_W | Last captured write data |
| bufWrite | output | 1 | One-cycle page-buffer store pulse |
| pageOpen | output | 1 | Page window running |
| busy | output | 1 | Programming interval in progress |

## Verification
The bench builds the block with `WINDOW_CYC` = 40 and `PROG_CYC` = 60, keeping `ADDR_W` = 17 and `DATA_W` = 32. With those values the whole sequence fits in a few hundred cycles: window expiry, the full busy interval, retriggering close to the end of a window, and a write held open longer than a window. At the default values (about 150 µs and 6 ms at 50 MHz) the same corners are out of reach in a short run. Writes in both strobe orders, writes with output enable low, strobes during busy, and a bare write-enable pulse are each compared against the behavioural model on every cycle.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  // synchronised view of the host strobe pins
  typedef struct packed {
    logic csN;
    logic weN;
    logic oeN;
  } strobeSet_t;

  // control to datapath capture commands
  typedef struct packed {
    logic takeAddr;
    logic takeData;
  } dpStrobe_t;

endpackage

// File: rtl/pwc_sync.sv
module pwc_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage <= {STAGES{RST_VAL}};
    else        stage <= {stage[STAGES-2:0], d};
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/pwc_interval.sv
module pwc_interval #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic advance,
  output logic expire
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt;

  assign expire = advance && !restart && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (advance) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/pwc_datapath.sv
module pwc_datapath
  import pwc_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  dpStrobe_t         ctl,
  output strobeSet_t        syncd,
  output logic [ADDR_W-1:0] capAddr,
  output logic [DATA_W-1:0] capData
);
  localparam int PINS = $bits(strobeSet_t);

  logic [PINS-1:0] rawPins;
  logic [PINS-1:0] cleanPins;

  assign rawPins = {csN, weN, oeN};

  pwc_sync #(.W(PINS), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rawPins), .q(cleanPins)
  );

  assign syncd = strobeSet_t'(cleanPins);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capAddr <= '0;
      capData <= '0;
    end else begin
      if (ctl.takeAddr) capAddr <= addrIn;
      if (ctl.takeData) capData <= dataIn;
    end
  end
endmodule

// File: rtl/pwc_control.sv
module pwc_control
  import pwc_pkg::*;
#(
  parameter int WINDOW_CYC = 7500,
  parameter int PROG_CYC = 300000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  strobeSet_t syncd,
  output dpStrobe_t  ctl,
  output logic       bufWrite,
  output logic       pageOpen,
  output logic       busy
);
  logic csPrev, wePrev;
  logic inWrite, dirty;
  logic bothLow, bothLowPrev, weFall, oeHigh;
  logic startW, endW;
  logic winRestart, winAdvance, winExpire;
  logic progStart, progExpire;

  assign bothLow     = !syncd.csN && !syncd.weN;
  assign bothLowPrev = !csPrev && !wePrev;
  assign weFall      = wePrev && !syncd.weN;
  assign oeHigh      = syncd.oeN;

  assign startW = !busy && oeHigh && bothLow && !bothLowPrev && !inWrite;
  assign endW   = !busy && inWrite && !bothLow;

  assign winRestart = !busy && oeHigh && weFall;
  assign winAdvance = pageOpen && !inWrite;
  assign progStart  = winExpire && dirty;

  assign ctl.takeAddr = startW;
  assign ctl.takeData = endW;

  pwc_interval #(.LEN(WINDOW_CYC)) u_window (
    .clk(clk), .rst_n(rst_n), .restart(winRestart),
    .advance(winAdvance), .expire(winExpire)
  );

  pwc_interval #(.LEN(PROG_CYC)) u_program (
    .clk(clk), .rst_n(rst_n), .restart(progStart),
    .advance(busy), .expire(progExpire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csPrev   <= 1'b1;
      wePrev   <= 1'b1;
      inWrite  <= 1'b0;
      dirty    <= 1'b0;
      bufWrite <= 1'b0;
      pageOpen <= 1'b0;
      busy     <= 1'b0;
    end else begin
      csPrev   <= syncd.csN;
      wePrev   <= syncd.weN;
      bufWrite <= endW;

      if (startW)    inWrite <= 1'b1;
      else if (endW) inWrite <= 1'b0;

      if (endW)           dirty <= 1'b1;
      else if (winExpire) dirty <= 1'b0;

      if (winRestart)     pageOpen <= 1'b1;
      else if (winExpire) pageOpen <= 1'b0;

      if (progStart)       busy <= 1'b1;
      else if (progExpire) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/page_write_capture.sv
module page_write_capture
  import pwc_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 32,
  parameter int WINDOW_CYC = 7500,
  parameter int PROG_CYC = 300000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] capAddr,
  output logic [DATA_W-1:0] capData,
  output logic              bufWrite,
  output logic              pageOpen,
  output logic              busy
);
  strobeSet_t syncd;
  dpStrobe_t  ctl;

  pwc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(2)) u_dp (
    .clk(clk), .rst_n(rst_n), .csN(csN), .weN(weN), .oeN(oeN),
    .addrIn(addrIn), .dataIn(dataIn), .ctl(ctl), .syncd(syncd),
    .capAddr(capAddr), .capData(capData)
  );

  pwc_control #(.WINDOW_CYC(WINDOW_CYC), .PROG_CYC(PROG_CYC)) u_ctl (
    .clk(clk), .rst_n(rst_n), .syncd(syncd), .ctl(ctl),
    .bufWrite(bufWrite), .pageOpen(pageOpen), .busy(busy)
  );
endmodule

// File: rtl/page_write_capture_chk.sv
module page_write_capture_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 32,
  parameter int PROG_CYC = 300000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] capAddr,
  input logic [DATA_W-1:0] capData,
  input logic              bufWrite,
  input logic              pageOpen,
  input logic              busy
);
  int unsigned busyRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busyRun <= 0;
    else if (busy) busyRun <= busyRun + 1;
    else           busyRun <= 0;
  end

  AST_BUSY_EXCLUDES_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pageOpen); // R7

  AST_BUSY_FROM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pageOpen)); // R7

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && busyRun != 0) |-> busyRun == PROG_CYC); // R8

  AST_NO_PULSE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !bufWrite); // R9

  AST_CAPTURE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(capAddr) && $stable(capData))); // R9

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bufWrite |=> !bufWrite); // R4
endmodule

bind page_write_capture page_write_capture_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYC(PROG_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .capAddr(capAddr), .capData(capData),
  .bufWrite(bufWrite), .pageOpen(pageOpen), .busy(busy)
);

// File: tb/page_write_capture_tb.sv
module page_write_capture_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;
  localparam int DW = 32;
  localparam int WIN = 40;
  localparam int PROG = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [AW-1:0] addrIn = '0;
  logic [DW-1:0] dataIn = '0;
  logic [AW-1:0] capAddr;
  logic [DW-1:0] capData;
  logic bufWrite, pageOpen, busy;

  always #(CLK_PERIOD / 2) clk = ~clk;

  page_write_capture #(.ADDR_W(AW), .DATA_W(DW), .WINDOW_CYC(WIN), .PROG_CYC(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .csN(csN), .weN(weN), .oeN(oeN),
    .addrIn(addrIn), .dataIn(dataIn), .capAddr(capAddr), .capData(capData),
    .bufWrite(bufWrite), .pageOpen(pageOpen), .busy(busy)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  string curReq = "R1";

  // behavioural reference: pin history queues and plain counters
  bit qCs[$], qWe[$], qOe[$];
  bit mCsPrev, mWePrev;
  bit mInWrite, mDirty;
  int mWinCnt, mProgCnt;
  logic [AW-1:0] mAddr;
  logic [DW-1:0] mData;
  bit mPulse, mOpen, mBusy;

  task automatic modelReset();
    qCs = '{1, 1}; qWe = '{1, 1}; qOe = '{1, 1};
    mCsPrev = 1; mWePrev = 1; mInWrite = 0; mDirty = 0;
    mWinCnt = 0; mProgCnt = 0; mAddr = '0; mData = '0;
    mPulse = 0; mOpen = 0; mBusy = 0;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rst_n) modelReset();
    else begin
      bit cs, we, oe, low, lowPrev, weDrop, start, stop;
      cs = qCs[0]; we = qWe[0]; oe = qOe[0];
      low = !cs && !we;
      lowPrev = !mCsPrev && !mWePrev;
      weDrop = mWePrev && !we;
      if (mBusy) begin
        mPulse = 0;
        if (mProgCnt == PROG - 1) begin mBusy = 0; mProgCnt = 0; end
        else mProgCnt++;
      end else begin
        start = oe && low && !lowPrev && !mInWrite;
        stop = mInWrite && !low;
        mPulse = stop;
        if (weDrop && oe) begin
          mOpen = 1; mWinCnt = 0;
        end else if (mOpen && !mInWrite) begin
          if (mWinCnt == WIN - 1) begin
            mOpen = 0; mWinCnt = 0;
            if (mDirty) begin mBusy = 1; mProgCnt = 0; mDirty = 0; end
          end else mWinCnt++;
        end
        if (stop) begin mData = dataIn; mDirty = 1; mInWrite = 0; end
        if (start) begin mAddr = addrIn; mInWrite = 1; end
      end
      mCsPrev = cs; mWePrev = we;
      void'(qCs.pop_front()); void'(qWe.pop_front()); void'(qOe.pop_front());
    end
    qCs.push_back(csN); qWe.push_back(weN); qOe.push_back(oeN);
    if (!rst_n) begin
      qCs = '{1, 1}; qWe = '{1, 1}; qOe = '{1, 1};
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      vectors++;
      if (capAddr !== mAddr || capData !== mData || bufWrite !== mPulse ||
          pageOpen !== mOpen || busy !== mBusy) begin
        miscompares++;
        $display("FAIL %s t=%0t capAddr=%h/%h capData=%h/%h bufWrite=%b/%b pageOpen=%b/%b busy=%b/%b (actual/expected)",
                 curReq, $time, capAddr, mAddr, capData, mData, bufWrite, mPulse,
                 pageOpen, mOpen, busy, mBusy);
      end
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // write controlled by write enable: CS low first, WE pulses inside it
  task automatic writeWeLed(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); addrIn = a; dataIn = d; csN = 0;
    waitCyc(3); weN = 0;
    waitCyc(4); weN = 1;
    waitCyc(4); csN = 1;
    waitCyc(3);
  endtask

  // write controlled by chip select: WE low first, CS pulses inside it
  task automatic writeCsLed(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); addrIn = a; dataIn = d; weN = 0;
    waitCyc(3); csN = 0;
    waitCyc(4); csN = 1;
    waitCyc(4); weN = 1;
    waitCyc(3);
  endtask

  task automatic report();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    curReq = "R1";
    waitCyc(3);
    rst_n = 1'b1;
    waitCyc(5);

    curReq = "R3"; writeWeLed(17'h1A5C3, 32'hDEAD_BEEF);
    curReq = "R4"; writeCsLed(17'h00F0F, 32'h1234_5678);
    curReq = "R5"; waitCyc(10);
    curReq = "R6"; writeWeLed(17'h1FFFF, 32'hA5A5_5A5A);
    waitCyc(20);
    @(negedge clk); weN = 0; waitCyc(3); weN = 1;
    waitCyc(30);
    curReq = "R7"; waitCyc(20);
    curReq = "R9";
    writeWeLed(17'h0AAAA, 32'hFFFF_0000);
    writeCsLed(17'h15555, 32'h0000_FFFF);
    curReq = "R8"; waitCyc(PROG);

    curReq = "R2"; oeN = 0;
    writeWeLed(17'h01234, 32'hCAFE_F00D);
    waitCyc(WIN + 10);
    oeN = 1; waitCyc(3);

    curReq = "R10";
    @(negedge clk); weN = 0; waitCyc(3); weN = 1;
    waitCyc(WIN + 10);

    curReq = "R11";
    @(negedge clk); addrIn = 17'h0BEEF; dataIn = 32'h0BAD_C0DE; csN = 0; weN = 0;
    waitCyc(WIN + 20);
    csN = 1; waitCyc(2); weN = 1;
    waitCyc(WIN + 10);
    curReq = "R8"; waitCyc(PROG + 10);

    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      report();
    end
  end
endmodule